// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets synchronous logic use an external asynchronous static RAM with an 8-bit data bus. Requests arrive on a valid/ready handshake that carries a write flag, a 21-bit address and a write byte. The controller drives the RAM's two chip enables (one active-low, one active-high), its active-low output enable and its active-low write enable. A read returns its byte together with a one-cycle response pulse. The bidirectional data bus appears as three pad-side signals: an output byte, a drive enable and an input byte. The tri-state pad itself sits outside the block.

Every phase length is given as a time in picoseconds. At elaboration it is turned into a whole number of clock cycles: the time is divided by the clock period and rounded up, and the result is never less than one cycle. From reset the controller waits for a power-up interval before it accepts the first request.

The state machine has seven states. PWRUP waits for the power-up timer and then goes to IDLE. IDLE accepts a request and goes to RD_ACC for a read or to WR_SETUP for a write. RD_ACC holds the read strobes for the access time and then goes to RD_TURN. RD_TURN keeps the bus released for the turnaround time and then returns to IDLE. WR_SETUP presents the address with write enable high and then goes to WR_STROBE. WR_STROBE pulls write enable low and drives the data, then goes to WR_HOLD. WR_HOLD raises write enable while the data is still driven and then returns to IDLE.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset, and until the power-up interval has elapsed, every strobe is inactive: sram_ce_n=1, sram_ce=0, sram_oe_n=1, sram_we_n=1 and sram_dq_oe=0. req_ready stays low until the cycle after PWR_CYC+1 clock edges have passed since reset was released.
- R2: req_ready is high only in IDLE, and while it is high every strobe is inactive. A request is taken on a clock edge at which req_valid and req_ready are both 1. A request held valid while ready is low waits and is taken later.
- R3: A read selects the chip (sram_ce_n=0, sram_ce=1) with sram_oe_n=0 and sram_we_n=1 for RD_CYC cycles, starting in the cycle after acceptance. RD_CYC is the larger of ceil(access/clk) and ceil(read cycle/clk)-TURN_CYC, and at least 1. That gives 2 at a 10 ns clock with a 12 ns access.
- R4: The read byte is sampled from sram_dq_i at the edge that ends the last access cycle. rsp_valid is high for exactly the following cycle, with that byte on rsp_rdata.
- R5: After a read, the chip is deselected with output enable high for TURN_CYC = ceil(high-Z delay/clk) cycles before req_ready returns.
- R6: A write runs three phases. WR_SETUP lasts SU_CYC cycles: chip selected, write enable high, no drive. WR_STROBE lasts PULSE_CYC = ceil(max(pulse, data setup)/clk) cycles: write enable low and data driven. WR_HOLD lasts HOLD_CYC cycles: write enable high and data still driven. Then everything is released.
- R7: The data driver is never enabled while sram_oe_n is 0. Output enable stays high through the whole of a write.
- R8: sram_addr does not change while the chip stays selected, and sram_dq_o does not change while the driver stays enabled.
- R9: A write occupies SU_CYC+PULSE_CYC+HOLD_CYC cycles and is at least ceil(write cycle/clk) long. A read occupies RD_CYC+TURN_CYC cycles. Back-to-back requests run with no extra idle cycle beyond the one IDLE cycle used for acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Byte returned by a read |
| sram_ce_n | output | 1 | Active-low chip enable |
| sram_ce | output | 1 | Active-high chip enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_addr | output | ADDR_W | RAM address pins |
| sram_dq_o | output | DATA_W | Byte toward the data pad |
| sram_dq_oe | output | 1 | Pad drive enable |
| sram_dq_i | input | DATA_W | Byte received from the data pad |

## Verification
The checks use a 10 ns clock and the default times, so a read keeps its strobes for two cycles after acceptance. Its response pulse comes three edges after acceptance, and the block is ready again after the fourth edge. A write is selected for three cycles, with write enable low only in the second, and is ready again after the fourth edge. The bench model counts edges from each acceptance and compares every pin in the middle of every cycle. The bench's RAM model returns a poison byte until the chip has been selected with output enable low for two edges, so early sampling shows up as wrong data. It stores a byte only on the rising edge of write enable, and only if the data is still driven at that edge.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_HOLD
    } ctl_state_e;

    // active-high view of the RAM strobes; polarity is fixed at the top
    typedef struct packed {
        logic sel;
        logic oe;
        logic we;
        logic drv;
    } strobe_t;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_pwrup.sv
`timescale 1ns/1ps
module sram_ctl_pwrup #(
    parameter int CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int W = (CYC < 2) ? 1 : $clog2(CYC + 1);

    logic [W-1:0] cnt_q;
    logic         done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == W'(CYC - 1)) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done = done_q;

endmodule

// File: rtl/sram_ctl_phase_timer.sv
`timescale 1ns/1ps
module sram_ctl_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    // a phase loaded with N lasts N cycles; last marks its final cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 8,
    parameter int PH_W      = 2,
    parameter int RD_CYC    = 2,
    parameter int TURN_CYC  = 1,
    parameter int SU_CYC    = 1,
    parameter int PULSE_CYC = 1,
    parameter int HOLD_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_done,
    input  logic              tmr_last,
    output logic              tmr_load,
    output logic [PH_W-1:0]   tmr_val,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output strobe_t           strobe,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    ctl_state_e state_q, state_nx;
    strobe_t    strobe_nx, strobe_q;
    logic       accept;
    logic       rd_capture;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              rsp_q;

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_ready && req_valid;
    assign rd_capture = (state_q == ST_RD_ACC) && tmr_last;

    // next state and phase loading
    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_PWRUP: begin
                if (pwr_done) state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_nx = ST_WR_SETUP;
                        tmr_val  = PH_W'(SU_CYC);
                    end else begin
                        state_nx = ST_RD_ACC;
                        tmr_val  = PH_W'(RD_CYC);
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_last) begin
                    state_nx = ST_RD_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = PH_W'(TURN_CYC);
                end
            end
            ST_RD_TURN: begin
                if (tmr_last) state_nx = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (tmr_last) begin
                    state_nx = ST_WR_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = PH_W'(PULSE_CYC);
                end
            end
            ST_WR_STROBE: begin
                if (tmr_last) begin
                    state_nx = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = PH_W'(HOLD_CYC);
                end
            end
            ST_WR_HOLD: begin
                if (tmr_last) state_nx = ST_IDLE;
            end
            default: state_nx = ST_PWRUP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PWRUP;
        else        state_q <= state_nx;
    end

    // strobe decode from the state being entered, so pins line up with it
    always_comb begin
        strobe_nx = '0;
        unique case (state_nx)
            ST_RD_ACC:    begin strobe_nx.sel = 1'b1; strobe_nx.oe = 1'b1; end
            ST_WR_SETUP:  begin strobe_nx.sel = 1'b1; end
            ST_WR_STROBE: begin strobe_nx.sel = 1'b1; strobe_nx.we = 1'b1; strobe_nx.drv = 1'b1; end
            ST_WR_HOLD:   begin strobe_nx.sel = 1'b1; strobe_nx.drv = 1'b1; end
            default:      strobe_nx = '0;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rsp_q    <= 1'b0;
        end else begin
            strobe_q <= strobe_nx;
            rsp_q    <= rd_capture;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (rd_capture) rdata_q <= ram_rdata;
        end
    end

    assign strobe    = strobe_q;
    assign ram_addr  = addr_q;
    assign ram_wdata = wdata_q;
    assign rsp_valid = rsp_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_async_ctl.sv
`timescale 1ns/1ps
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int DATA_W   = 8,
    parameter int CLK_PS   = 10000,
    parameter int T_PWR_PS = 1000000000,
    parameter int T_AA_PS  = 12000,
    parameter int T_RC_PS  = 12000,
    parameter int T_WC_PS  = 12000,
    parameter int T_PWE_PS = 8000,
    parameter int T_SD_PS  = 6000,
    parameter int T_HZ_PS  = 6000,
    parameter int HOLD_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sram_ce_n,
    output logic              sram_ce,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);
    localparam int PWR_CYC   = imax(1, cdiv(T_PWR_PS, CLK_PS));
    localparam int TURN_CYC  = imax(1, cdiv(T_HZ_PS, CLK_PS));
    localparam int RD_CYC    = imax(1, imax(cdiv(T_AA_PS, CLK_PS), cdiv(T_RC_PS, CLK_PS) - TURN_CYC));
    localparam int PULSE_CYC = imax(1, imax(cdiv(T_PWE_PS, CLK_PS), cdiv(T_SD_PS, CLK_PS)));
    localparam int SU_CYC    = imax(1, cdiv(T_WC_PS, CLK_PS) - PULSE_CYC - HOLD_CYC);
    localparam int PH_MAX    = imax(imax(RD_CYC, TURN_CYC), imax(imax(SU_CYC, PULSE_CYC), HOLD_CYC));
    localparam int PH_W      = $clog2(PH_MAX + 1);

    if (HOLD_CYC < 1 || RD_CYC < 1 || TURN_CYC < 1 || PULSE_CYC < 1 || SU_CYC < 1) begin : g_bad_phase
        $error("every phase must last at least one clock cycle");
    end

    logic            pwr_done;
    logic            tmr_last;
    logic            tmr_load;
    logic [PH_W-1:0] tmr_val;
    strobe_t         strobe;

    sram_ctl_pwrup #(
        .CYC (PWR_CYC)
    ) u_pwrup (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pwr_done)
    );

    sram_ctl_phase_timer #(
        .W (PH_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_ctl_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PH_W      (PH_W),
        .RD_CYC    (RD_CYC),
        .TURN_CYC  (TURN_CYC),
        .SU_CYC    (SU_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_done  (pwr_done),
        .tmr_last  (tmr_last),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .strobe    (strobe),
        .ram_addr  (sram_addr),
        .ram_wdata (sram_dq_o),
        .ram_rdata (sram_dq_i)
    );

    assign sram_ce_n  = ~strobe.sel;
    assign sram_ce    =  strobe.sel;
    assign sram_oe_n  = ~strobe.oe;
    assign sram_we_n  = ~strobe.we;
    assign sram_dq_oe =  strobe.drv;

endmodule

// File: rtl/sram_async_ctl_chk.sv
`timescale 1ns/1ps
module sram_async_ctl_chk #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              sram_ce_n,
    input logic              sram_ce,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq_o,
    input logic              sram_dq_oe
);
    // R7
    drive_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    // R6
    strobe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_dq_oe && !sram_ce_n && sram_ce));

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    // R8
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o));

    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

    // R5
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (sram_ce_n && !req_ready));

    // R6
    we_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (sram_dq_oe && !sram_ce_n));

endmodule

bind sram_async_ctl sram_async_ctl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .sram_ce_n  (sram_ce_n),
    .sram_ce    (sram_ce),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_addr  (sram_addr),
    .sram_dq_o  (sram_dq_o),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/tb_sram_async_ctl.sv
`timescale 1ns/1ps
module tb_sram_async_ctl;
    localparam int CLK_NS = 10;
    localparam int CLK_PS = CLK_NS * 1000;
    // phase lengths worked out by hand from the requirement formulas at 10 ns
    localparam int PWR  = 30;   // 300 ns
    localparam int RD   = 2;    // ceil(12/10)
    localparam int TURN = 1;    // ceil(6/10)
    localparam int SU   = 1;    // ceil(12/10) - 1 - 1 -> min 1
    localparam int PUL  = 1;    // ceil(8/10)
    localparam int HLD  = 1;
    localparam int RD_NEED = 2; // edges selected before RAM data is valid

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        sram_ce_n, sram_ce, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [20:0] sram_addr;
    logic [7:0]  sram_dq_o;
    logic [7:0]  sram_dq_i = 8'hEE;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    sram_async_ctl #(
        .CLK_PS   (CLK_PS),
        .T_PWR_PS (PWR * CLK_PS)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .sram_ce_n  (sram_ce_n),
        .sram_ce    (sram_ce),
        .sram_oe_n  (sram_oe_n),
        .sram_we_n  (sram_we_n),
        .sram_addr  (sram_addr),
        .sram_dq_o  (sram_dq_o),
        .sram_dq_oe (sram_dq_oe),
        .sram_dq_i  (sram_dq_i)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural RAM with timing monitors ----------------
    logic [7:0] ram [int];
    int rd_cnt = 0;
    int we_lo  = 0;
    logic we_prev = 1'b1;
    wire ram_sel = !sram_ce_n && sram_ce;

    always @(posedge clk) begin
        if (ram_sel && !sram_oe_n && sram_we_n) rd_cnt <= rd_cnt + 1;
        else                                    rd_cnt <= 0;
    end

    always @(negedge clk) begin
        if (ram_sel && !sram_oe_n && sram_we_n && rd_cnt >= RD_NEED - 1)
            sram_dq_i <= ram.exists(int'(sram_addr)) ? ram[int'(sram_addr)] : 8'h00;
        else
            sram_dq_i <= 8'hEE;
        if (sram_dq_oe && ram_sel && !sram_oe_n && sram_we_n)
            chk("R7", "bus contention", 1, 0);
        if (ram_sel && !sram_we_n) begin
            we_lo++;
            if (!sram_dq_oe) chk("R6", "data not driven in strobe", 0, 1);
        end
        if (!we_prev && sram_we_n) begin
            chk("R6", "strobe width ok", (we_lo * CLK_PS >= 8000 && we_lo * CLK_PS >= 6000) ? 1 : 0, 1);
            chk("R6", "data held at strobe end", int'(sram_dq_oe), 1);
            if (sram_dq_oe) ram[int'(sram_addr)] = sram_dq_o;
            we_lo = 0;
        end
        we_prev = sram_we_n;
    end

    // ---------------- cycle reference model ----------------
    int         m_up = 0;
    int         m_op = 0;   // 0 none, 1 read, 2 write
    int         m_age = 0;
    logic [20:0] m_addr = '0;
    logic [7:0]  m_data = '0;
    logic [7:0]  m_rexp = '0;
    logic [7:0]  sb [int];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_up = 0; m_op = 0; m_age = 0;
        end else begin
            if (m_op == 0) begin
                if (m_up >= PWR + 1 && req_valid) begin
                    m_op   = req_write ? 2 : 1;
                    m_age  = 0;
                    m_addr = req_addr;
                    m_data = req_wdata;
                    if (req_write) sb[int'(req_addr)] = req_wdata;
                    else m_rexp = sb.exists(int'(req_addr)) ? sb[int'(req_addr)] : 8'h00;
                end
            end else begin
                m_age++;
                if ((m_op == 1 && m_age == RD + TURN) || (m_op == 2 && m_age == SU + PUL + HLD))
                    m_op = 0;
            end
            if (m_up < 1000000) m_up++;
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            bit e_sel, e_oe, e_we, e_drv, e_rsp, e_rdy;
            string tag;
            e_sel = 0; e_oe = 0; e_we = 0; e_drv = 0;
            e_rdy = rst_n && (m_up >= PWR + 1) && (m_op == 0);
            e_rsp = (m_op == 1) && (m_age == RD);
            tag = (!rst_n || m_up < PWR + 2) ? "R1" : "R2";
            if (m_op == 1 && m_age < RD) begin
                e_sel = 1; e_oe = 1; tag = "R3";
            end else if (m_op == 1) begin
                tag = "R5";
            end else if (m_op == 2) begin
                tag = "R6";
                if (m_age < SU) e_sel = 1;
                else if (m_age < SU + PUL) begin e_sel = 1; e_we = 1; e_drv = 1; end
                else if (m_age < SU + PUL + HLD) begin e_sel = 1; e_drv = 1; end
            end
            chk(e_rdy ? "R2" : (m_op != 0 ? "R9" : tag), "req_ready", int'(req_ready), int'(e_rdy));
            chk(tag, "sram_ce_n", int'(sram_ce_n), int'(!e_sel));
            chk(tag, "sram_ce",   int'(sram_ce),   int'(e_sel));
            chk(m_op == 2 ? "R7" : tag, "sram_oe_n", int'(sram_oe_n), int'(!e_oe));
            chk(tag, "sram_we_n", int'(sram_we_n), int'(!e_we));
            chk(tag, "sram_dq_oe", int'(sram_dq_oe), int'(e_drv));
            chk("R4", "rsp_valid", int'(rsp_valid), int'(e_rsp));
            if (e_sel) chk("R8", "sram_addr", int'(sram_addr), int'(m_addr));
            if (e_drv) chk("R8", "sram_dq_o", int'(sram_dq_o), int'(m_data));
            if (e_rsp) chk("R4", "rsp_rdata", int'(rsp_rdata), int'(m_rexp));
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input bit w, input logic [20:0] a, input logic [7:0] d);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: request held valid through the power-up wait, taken afterwards
        send(1'b0, 21'h000005, 8'h00);
        // R6, R9: back-to-back writes including both address extremes
        send(1'b1, 21'h000000, 8'h3C);
        send(1'b1, 21'h1FFFFF, 8'hC3);
        send(1'b1, 21'h012345, 8'h5A);
        // R3, R4: back-to-back read-back
        send(1'b0, 21'h1FFFFF, 8'h00);
        send(1'b0, 21'h000000, 8'h00);
        send(1'b0, 21'h012345, 8'h00);
        // write then read the same word
        send(1'b1, 21'h012345, 8'hFF);
        send(1'b0, 21'h012345, 8'h00);
        // R5, R7: read followed directly by a write, then read again
        send(1'b0, 21'h000000, 8'h00);
        send(1'b1, 21'h000000, 8'h81);
        send(1'b0, 21'h000000, 8'h00);
        // mixed pattern with idle gaps
        for (int i = 0; i < 12; i++) begin
            send(1'b1, 21'(i * 7919 + 3), 8'(i * 37 + 11));
            repeat (i % 3) @(negedge clk);
        end
        for (int i = 11; i >= 0; i--) begin
            send(1'b0, 21'(i * 7919 + 3), 8'h00);
            repeat (i % 2) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        // R6: final comparison of stored words against the scoreboard
        foreach (sb[k]) begin
            chk("R6", "stored word", ram.exists(k) ? int'(ram[k]) : -1, int'(sb[k]));
        end
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

endmodule